// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This controller sits on the host side of a three-wire serial EEPROM. It exposes a single command port. On that port the host presents an operation code, a word address and write data, together with an organisation select that picks byte-wide or 16-bit-wide access. The controller serialises each command into a chip-select framed bit stream on a derived serial clock. It collects the returned bits for reads and drops the leading zero that the memory sends before the data. For programming operations it reopens chip select and watches the data-out line until the memory reports ready.

The command port uses valid/ready. `cmd_ready` is high only while the controller is idle. A command is taken on the cycle where `cmd_valid` and `cmd_ready` are both high. After that, `cmd_ready` stays low, which applies back-pressure, until the command has finished. Completion is a one-cycle `rsp_valid` pulse with no stall path. The host must capture the pulse, but `rsp_rdata` and `rsp_timeout` remain valid until the next command is accepted. The serial clock half-period, the minimum chip-select low gap and the ready-poll limit are all parameters in system clock cycles. This lets one netlist meet the timing of any supply range.

Top module: `mw_eeprom_host`

## Requirements
- R1: `cmd_ready` is 1 exactly when the controller is idle. It is 1 after reset and drops in the cycle after acceptance. It returns to 1 in the cycle after the single-cycle `rsp_valid` pulse. `cmd_op` codes are: 0 read, 1 write, 2 erase one location, 3 programming enable, 4 programming disable, 5 erase all, 6 write all, and 7, which behaves as programming disable.
- R2: Each frame begins with `ee_cs` rising while `ee_sk` is low. The controller then sends a 1 start bit, a 2-bit opcode and the address, each MSB first. The opcodes are read 10, write 01, erase 11 and 00 for the four bulk operations. The address is 7 bits when `org_wide`=0 and 6 bits when `org_wide`=1. A read frame has 3+A+1+D serial clock pulses in total, where D is 8 or 16.
- R3: The bulk operations put a 2-bit subcode in the two most significant address positions and zeros in the rest. The subcodes are: enable 11, erase all 10, write all 01, disable 00.
- R4: Write and write-all send D data bits MSB first right after the address. In byte mode these are the low byte of `cmd_wdata`.
- R5: For a read, the first returned bit is discarded. `rsp_rdata` holds the next D bits, assembled MSB first and zero-extended in byte mode. For other commands it is zero. It stays stable while idle.
- R6: Every serial clock high phase and low phase lasts exactly `HALF_DIV` clocks. `ee_sk` is high only while `ee_cs` is high. `ee_di` never changes while `ee_sk` stays high. `ee_do` is sampled in the last clock of each low phase.
- R7: After every fall of `ee_cs`, it stays low for at least `GAP_CYC` clocks before rising again.
- R8: After write, erase, erase all and write all, the controller lowers `ee_cs` for the gap and then raises it again with no serial clock pulses. It completes once `ee_do` reads 1, with `rsp_timeout`=0.
- R9: If `ee_do` has not read 1 by the time `ee_cs` has been high for `POLL_LIMIT`+1 clocks, the controller lowers `ee_cs` and completes with `rsp_timeout`=1. The flag clears when the next command is accepted.
- R10: `ee_cs` and `ee_sk` are low in the cycle of `rsp_valid` and after reset.
- R11: Organisation, opcode, address and data are captured at acceptance. Changing these inputs afterwards has no effect on the command in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Controller idle, command can be taken |
| cmd_op | input | 3 | Operation code (see R1) |
| cmd_addr | input | ADDR_W | Word address, low 6 bits used in 16-bit mode |
| cmd_wdata | input | DATA_W | Write data, low byte used in byte mode |
| org_wide | input | 1 | 1 selects 16-bit words, 0 selects bytes |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read result |
| rsp_timeout | output | 1 | Ready poll expired |
| ee_cs | output | 1 | Memory chip select |
| ee_sk | output | 1 | Memory serial clock |
| ee_di | output | 1 | Serial data toward the memory |
| ee_do | input | 1 | Serial data and ready status from the memory |

## Verification
The bench builds the controller with `HALF_DIV`=2, `GAP_CYC`=3 and `POLL_LIMIT`=40. With these values a full command takes about a hundred clocks, so every location can be written and read back in both organisations against arithmetic patterns. A bus-level memory model holds busy for a chosen number of clocks. Setting that hold above the poll limit brings the timeout path within reach in a few dozen cycles. Frame lengths, phase widths and chip-select gaps are measured at the pins.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;

  typedef enum logic [2:0] {
    CMD_READ  = 3'd0,
    CMD_WRITE = 3'd1,
    CMD_ERASE = 3'd2,
    CMD_WREN  = 3'd3,
    CMD_WRDIS = 3'd4,
    CMD_ERALL = 3'd5,
    CMD_WRALL = 3'd6,
    CMD_RSVD  = 3'd7
  } mw_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_GAP,
    ST_POLL,
    ST_DONE
  } mw_state_e;

  // serial opcode placed after the start bit
  function automatic logic [1:0] cmd_opcode(mw_cmd_e c);
    case (c)
      CMD_READ:  return 2'b10;
      CMD_WRITE: return 2'b01;
      CMD_ERASE: return 2'b11;
      default:   return 2'b00;
    endcase
  endfunction

  // subcode carried in the top address bits of the bulk group
  function automatic logic [1:0] cmd_subcode(mw_cmd_e c);
    case (c)
      CMD_WREN:  return 2'b11;
      CMD_ERALL: return 2'b10;
      CMD_WRALL: return 2'b01;
      default:   return 2'b00;
    endcase
  endfunction

  function automatic logic cmd_programs(mw_cmd_e c);
    return (c == CMD_WRITE) || (c == CMD_ERASE) ||
           (c == CMD_ERALL) || (c == CMD_WRALL);
  endfunction

  function automatic logic cmd_has_data(mw_cmd_e c);
    return (c == CMD_WRITE) || (c == CMD_WRALL);
  endfunction

endpackage

// File: rtl/mw_sk_timer.sv
module mw_sk_timer #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!run)        cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/mw_frame_build.sv
module mw_frame_build import mw_eeprom_pkg::*; #(
  parameter int ADDR_W  = 7,
  parameter int DATA_W  = 16,
  parameter int FRAME_W = 3 + ADDR_W + DATA_W,
  parameter int CNT_W   = 6
) (
  input  mw_cmd_e             cmd,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                wide,
  output logic [FRAME_W-1:0]  frame,
  output logic [CNT_W-1:0]    sk_total
);
  always_comb begin
    int unsigned aw;
    int unsigned dw;
    int unsigned tx_n;
    int unsigned rx_n;
    logic [FRAME_W-1:0] afield;
    logic [FRAME_W-1:0] dfield;
    logic [FRAME_W-1:0] acc;

    aw = wide ? ADDR_W - 1 : ADDR_W;
    dw = wide ? DATA_W : DATA_W / 2;

    if (cmd_opcode(cmd) == 2'b00)
      afield = FRAME_W'(cmd_subcode(cmd)) << (aw - 2);
    else
      afield = FRAME_W'(addr) & ((FRAME_W'(1) << aw) - FRAME_W'(1));
    dfield = FRAME_W'(wdata) & ((FRAME_W'(1) << dw) - FRAME_W'(1));

    acc  = FRAME_W'({1'b1, cmd_opcode(cmd)});
    acc  = (acc << aw) | afield;
    tx_n = 3 + aw;
    if (cmd_has_data(cmd)) begin
      acc  = (acc << dw) | dfield;
      tx_n = tx_n + dw;
    end
    rx_n = (cmd == CMD_READ) ? dw + 1 : 0;

    frame    = acc << (FRAME_W - tx_n);
    sk_total = CNT_W'(tx_n + rx_n);
  end
endmodule

// File: rtl/mw_rx_assemble.sv
module mw_rx_assemble #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift_en,
  input  logic              bit_in,
  input  logic              wide,
  output logic [DATA_W-1:0] data
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] sr;

  // only the newest D samples survive, which drops the leading zero bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr <= '0;
    else if (clr)      sr <= '0;
    else if (shift_en) sr <= {sr[DATA_W-2:0], bit_in};
  end

  assign data = wide ? sr : {{(DATA_W-HALF_W){1'b0}}, sr[HALF_W-1:0]};
endmodule

// File: rtl/mw_eeprom_host.sv
module mw_eeprom_host import mw_eeprom_pkg::*; #(
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 16,
  parameter int HALF_DIV   = 4,
  parameter int GAP_CYC    = 8,
  parameter int POLL_LIMIT = 600000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              org_wide,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_timeout,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  input  logic              ee_do
);
  localparam int FRAME_W  = 3 + ADDR_W + DATA_W;
  localparam int MAX_SK   = 4 + ADDR_W + DATA_W;
  localparam int CNT_W    = $clog2(MAX_SK + 1);
  localparam int WAIT_MAX = (GAP_CYC > POLL_LIMIT) ? GAP_CYC : POLL_LIMIT;
  localparam int WW       = $clog2(WAIT_MAX + 1);
  localparam logic [WW-1:0] GAP_LAST  = WW'(GAP_CYC - 1);
  localparam logic [WW-1:0] POLL_LAST = WW'(POLL_LIMIT);

  mw_state_e          state;
  mw_cmd_e            cmd_e;
  logic [FRAME_W-1:0] frame_d, tx_sr;
  logic [CNT_W-1:0]   total_d, total_q, sk_cnt;
  logic [WW-1:0]      wait_cnt;
  logic               read_q, poll_pend, wide_q, timeout_q;
  logic               cs_q, sk_q, tick, accept, rx_shift;
  logic [DATA_W-1:0]  rx_data;

  assign cmd_e  = mw_cmd_e'(cmd_op);
  assign accept = cmd_valid && (state == ST_IDLE);

  mw_frame_build #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)
  ) u_frame (
    .cmd(cmd_e), .addr(cmd_addr), .wdata(cmd_wdata), .wide(org_wide),
    .frame(frame_d), .sk_total(total_d)
  );

  mw_sk_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(state == ST_SHIFT), .tick(tick)
  );

  assign rx_shift = (state == ST_SHIFT) && tick && !sk_q && read_q;

  mw_rx_assemble #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(accept), .shift_en(rx_shift),
    .bit_in(ee_do), .wide(wide_q), .data(rx_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      tx_sr     <= '0;
      total_q   <= '0;
      sk_cnt    <= '0;
      wait_cnt  <= '0;
      read_q    <= 1'b0;
      poll_pend <= 1'b0;
      wide_q    <= 1'b0;
      timeout_q <= 1'b0;
      cs_q      <= 1'b0;
      sk_q      <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            tx_sr     <= frame_d;
            total_q   <= total_d;
            sk_cnt    <= '0;
            read_q    <= (cmd_e == CMD_READ);
            poll_pend <= cmd_programs(cmd_e);
            wide_q    <= org_wide;
            timeout_q <= 1'b0;
            cs_q      <= 1'b1;
            sk_q      <= 1'b0;
            state     <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (!sk_q) begin
              sk_q <= 1'b1;
            end else begin
              sk_q   <= 1'b0;
              tx_sr  <= tx_sr << 1;
              sk_cnt <= sk_cnt + 1'b1;
              if (CNT_W'(sk_cnt + 1'b1) == total_q) begin
                cs_q     <= 1'b0;
                wait_cnt <= '0;
                state    <= ST_GAP;
              end
            end
          end
        end
        ST_GAP: begin
          if (wait_cnt == GAP_LAST) begin
            wait_cnt <= '0;
            if (poll_pend) begin
              poll_pend <= 1'b0;
              cs_q      <= 1'b1;
              state     <= ST_POLL;
            end else begin
              state <= ST_DONE;
            end
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        ST_POLL: begin
          if ((wait_cnt != '0) && ee_do) begin
            cs_q     <= 1'b0;
            wait_cnt <= '0;
            state    <= ST_GAP;
          end else if (wait_cnt == POLL_LAST) begin
            timeout_q <= 1'b1;
            cs_q      <= 1'b0;
            wait_cnt  <= '0;
            state     <= ST_GAP;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready   = (state == ST_IDLE);
  assign rsp_valid   = (state == ST_DONE);
  assign rsp_rdata   = read_q ? rx_data : '0;
  assign rsp_timeout = timeout_q;
  assign ee_cs       = cs_q;
  assign ee_sk       = sk_q;
  assign ee_di       = cs_q & tx_sr[FRAME_W-1];
endmodule

// File: rtl/mw_eeprom_host_chk.sv
module mw_eeprom_host_chk #(
  parameter int GAP_CYC = 8,
  parameter int DATA_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              rsp_valid,
  input logic              rsp_timeout,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              ee_cs,
  input logic              ee_sk,
  input logic              ee_di
);
  localparam int LW = $clog2(GAP_CYC + 2);
  localparam logic [LW-1:0] GAP_SAT = LW'(GAP_CYC);

  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 low_cnt <= GAP_SAT;
    else if (ee_cs)             low_cnt <= '0;
    else if (low_cnt < GAP_SAT) low_cnt <= low_cnt + 1'b1;
  end

  p_accept_drops_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_ready);
  p_done_reopens_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> cmd_ready && !rsp_valid);
  p_rdata_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready && !cmd_valid |=> $stable(rsp_rdata));
  p_sk_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |-> ee_cs);
  p_di_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk && $past(ee_sk) |-> $stable(ee_di));
  p_cs_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_cs) |-> low_cnt >= GAP_SAT);
  p_timeout_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready && !cmd_valid |=> $stable(rsp_timeout));
  p_quiet_at_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !ee_cs && !ee_sk);
endmodule

bind mw_eeprom_host mw_eeprom_host_chk #(.GAP_CYC(GAP_CYC), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .rsp_valid(rsp_valid), .rsp_timeout(rsp_timeout), .rsp_rdata(rsp_rdata),
  .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di)
);

// File: tb/mw_eeprom_host_test.sv
module mw_eeprom_host_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;
  localparam int GAP  = 3;
  localparam int PLIM = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [2:0] cmd_op = '0;
  logic [6:0] cmd_addr = '0;
  logic [15:0] cmd_wdata = '0;
  logic org_wide = 1'b1;
  logic rsp_valid, rsp_timeout;
  logic [15:0] rsp_rdata;
  logic ee_cs, ee_sk, ee_di, ee_do;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mw_eeprom_host #(.ADDR_W(7), .DATA_W(16), .HALF_DIV(HALF), .GAP_CYC(GAP),
                   .POLL_LIMIT(PLIM)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .org_wide(org_wide), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_timeout(rsp_timeout), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
    .ee_do(ee_do));

  // ---------------- memory model at the pins ----------------
  longint cyc = 0;
  longint busy_until = 0;
  int busy_len = 10;
  bit dev_wide = 1'b1;
  bit en = 1'b0;
  logic [15:0] mem [64];
  int m_cnt = 0, m_aw, m_dw, m_addr, m_sub;
  logic [31:0] m_sr = '0;
  logic [1:0] m_op = '0;
  bit reading = 1'b0;
  logic do_m = 1'b0;
  logic [15:0] rdbuf = '0;

  always @(posedge clk) cyc <= cyc + 1;

  assign ee_do = ee_cs && (reading ? do_m : (cyc >= busy_until));

  task automatic put_loc(int a, logic [15:0] v);
    if (dev_wide) mem[a] = v;
    else if (a[0]) mem[a >> 1][15:8] = v[7:0];
    else mem[a >> 1][7:0] = v[7:0];
  endtask

  always @(posedge ee_sk or negedge ee_cs) begin
    if (!ee_cs) begin
      m_cnt = 0; reading = 0;
    end else begin
      m_cnt++;
      m_sr = {m_sr[30:0], ee_di};
      m_aw = dev_wide ? 6 : 7;
      m_dw = dev_wide ? 16 : 8;
      if (m_cnt == 3 + m_aw) begin
        m_op = 2'((m_sr >> m_aw) & 3);
        m_addr = int'(m_sr & ((32'd1 << m_aw) - 1));
        m_sub = m_addr >> (m_aw - 2);
        if (m_op == 2'b10) begin
          reading = 1; do_m = 1'b0;
          if (dev_wide) rdbuf = mem[m_addr];
          else rdbuf = {8'h00, m_addr[0] ? mem[m_addr >> 1][15:8] : mem[m_addr >> 1][7:0]};
        end else if (m_op == 2'b11 && en) begin
          put_loc(m_addr, 16'hFFFF); busy_until = cyc + busy_len;
        end else if (m_op == 2'b00) begin
          if (m_sub == 3) en = 1;
          else if (m_sub == 0) en = 0;
          else if (m_sub == 2 && en) begin
            for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;
            busy_until = cyc + busy_len;
          end
        end
      end else if (m_cnt > 3 + m_aw) begin
        if (reading) begin
          do_m = rdbuf[m_dw-1]; rdbuf = rdbuf << 1;
        end else if (m_cnt == 3 + m_aw + m_dw && en &&
                     (m_op == 2'b01 || (m_op == 2'b00 && m_sub == 1))) begin
          if (m_op == 2'b01) put_loc(m_addr, m_sr[15:0] & (dev_wide ? 16'hFFFF : 16'h00FF));
          else for (int i = 0; i < 64; i++)
            mem[i] = dev_wide ? m_sr[15:0] : {m_sr[7:0], m_sr[7:0]};
          busy_until = cyc + busy_len;
        end
      end
    end
  end

  // ---------------- pin monitor ----------------
  int lo_len = 100, hi_len = 0, run = 0, cur_rises = 0, last_rises = 0, last_hi = 0;
  int gap_viol = 0, sk_viol = 0, di_viol = 0, frames = 0;
  logic p_cs = 0, p_sk = 0, p_di = 0;

  always @(negedge clk) if (rst_n) begin
    if (ee_cs && !p_cs) begin
      if (lo_len < GAP) gap_viol++;
      frames++; cur_rises = 0; hi_len = 0; run = 1;
    end else if (p_cs && ee_sk != p_sk) begin
      if (run != HALF) sk_viol++;
      run = 1;
    end else if (ee_cs) run++;
    if (ee_sk && !p_sk) cur_rises++;
    if (ee_sk && p_sk && ee_di != p_di) di_viol++;
    if (ee_cs) hi_len++;
    if (!ee_cs && p_cs) begin last_rises = cur_rises; last_hi = hi_len; end
    lo_len = ee_cs ? 0 : lo_len + 1;
    p_cs = ee_cs; p_sk = ee_sk; p_di = ee_di;
  end

  // ---------------- helpers ----------------
  function automatic logic [15:0] pat16(int a, int s);
    return 16'((a * 291 + 19229 + s * 4099) & 16'hFFFF);
  endfunction
  function automatic logic [7:0] pat8(int a, int s);
    return 8'((a * 31 + 60 + s * 7) & 8'hFF);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic cs_at_done, ready_after;

  task automatic run_cmd(input logic [2:0] op, input logic [6:0] a,
                         input logic [15:0] d, output logic [15:0] rd, output logic to);
    int n;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_op = op; cmd_addr = a; cmd_wdata = d; org_wide = dev_wide; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    org_wide = !dev_wide; cmd_op = ~op; cmd_addr = ~a; cmd_wdata = ~d;  // R11 disturbance
    n = 0;
    while (!rsp_valid && n < 5000) begin @(negedge clk); n++; end
    rd = rsp_rdata; to = rsp_timeout; cs_at_done = ee_cs | ee_sk;
    @(negedge clk);
    ready_after = cmd_ready && !rsp_valid;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    logic to;
    for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    chk("R1 ready at reset", cmd_ready, 1);
    chk("R10 cs at reset", {ee_cs, ee_sk}, 0);
    chk("R1 no rsp at reset", rsp_valid, 0);
    rst_n = 1'b1;

    // write while device still disabled: frame goes out, poll sees ready
    dev_wide = 1;
    run_cmd(3'd1, 7'd5, 16'h1234, rd, to);
    chk("R8 poll frame without sk", last_rises, 0);
    chk("R8 no timeout", to, 0);
    chk("R10 cs low at done", cs_at_done, 0);
    chk("R1 ready after done", ready_after, 1);
    run_cmd(3'd0, 7'd5, 16'h0, rd, to);
    chk("R5 blank read", rd, 16'hFFFF);
    chk("R2 read frame length x16", last_rises, 3 + 6 + 1 + 16);

    run_cmd(3'd3, 7'd0, 16'h0, rd, to);
    chk("R3 enable frame length", last_rises, 3 + 6);
    chk("R5 zero rdata on non-read", rd, 0);

    // full 16-bit sweep
    for (int a = 0; a < 64; a++) begin
      run_cmd(3'd1, 7'(a), pat16(a, 0), rd, to);
      chk("R4/R8 x16 write", to, 0);
    end
    for (int a = 0; a < 64; a++) begin
      run_cmd(3'd0, 7'(a), 16'h0, rd, to);
      chk("R5/R11 x16 read", rd, pat16(a, 0));
    end

    // full byte sweep
    dev_wide = 0;
    for (int a = 0; a < 128; a++) begin
      run_cmd(3'd1, 7'(a), {8'hC3, pat8(a, 1)}, rd, to);
      chk("R4 x8 write", to, 0);
    end
    for (int a = 0; a < 128; a++) begin
      run_cmd(3'd0, 7'(a), 16'h0, rd, to);
      chk("R5/R2 x8 read", rd, {8'h00, pat8(a, 1)});
    end
    chk("R2 read frame length x8", last_rises, 3 + 7 + 1 + 8);

    run_cmd(3'd2, 7'd77, 16'h0, rd, to);
    run_cmd(3'd0, 7'd77, 16'h0, rd, to);
    chk("R2 erase x8", rd, 16'h00FF);
    dev_wide = 1;
    run_cmd(3'd2, 7'd9, 16'h0, rd, to);
    run_cmd(3'd0, 7'd9, 16'h0, rd, to);
    chk("R2 erase x16", rd, 16'hFFFF);
    run_cmd(3'd0, 7'd10, 16'h0, rd, to);
    chk("R2 neighbour kept", rd, {pat8(21, 1), pat8(20, 1)});

    // bulk operations
    run_cmd(3'd6, 7'd0, 16'hA55A, rd, to);
    chk("R3 write-all poll", to, 0);
    for (int a = 0; a < 64; a++) begin
      run_cmd(3'd0, 7'(a), 16'h0, rd, to);
      chk("R3 write-all x16", rd, 16'hA55A);
    end
    dev_wide = 0;
    run_cmd(3'd6, 7'd0, 16'h003C, rd, to);
    run_cmd(3'd0, 7'd101, 16'h0, rd, to);
    chk("R3 write-all x8", rd, 16'h003C);
    run_cmd(3'd5, 7'd0, 16'h0, rd, to);
    for (int a = 0; a < 128; a += 9) begin
      run_cmd(3'd0, 7'(a), 16'h0, rd, to);
      chk("R3 erase-all", rd, 16'h00FF);
    end

    dev_wide = 1;
    run_cmd(3'd4, 7'd0, 16'h0, rd, to);
    run_cmd(3'd1, 7'd2, 16'h0000, rd, to);
    run_cmd(3'd0, 7'd2, 16'h0, rd, to);
    chk("R3 disable blocks write", rd, 16'hFFFF);
    run_cmd(3'd3, 7'd0, 16'h0, rd, to);
    run_cmd(3'd7, 7'd0, 16'h0, rd, to);
    run_cmd(3'd1, 7'd3, 16'h0000, rd, to);
    run_cmd(3'd0, 7'd3, 16'h0, rd, to);
    chk("R1 code 7 disables", rd, 16'hFFFF);

    // timeout
    run_cmd(3'd3, 7'd0, 16'h0, rd, to);
    busy_len = 200;
    run_cmd(3'd1, 7'd4, 16'h0001, rd, to);
    chk("R9 timeout flag", to, 1);
    chk("R9 poll window", last_hi, PLIM + 1);
    chk("R10 cs low after timeout", cs_at_done, 0);
    while (cyc < busy_until + 2) @(negedge clk);
    busy_len = 10;
    run_cmd(3'd1, 7'd4, 16'h0002, rd, to);
    chk("R9 flag clears", to, 0);
    run_cmd(3'd0, 7'd4, 16'h0, rd, to);
    chk("R4 after timeout", rd, 16'h0002);

    chk("R7 cs gap", gap_viol, 0);
    chk("R6 sk phase width", sk_viol, 0);
    chk("R6 di steady", di_viol, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule